// File: doc/BRIEF.md
# Inbound Message Descriptor Generator

This block turns the segment stream of inbound messages and doorbells into two 64-bit descriptor words per message. Two message controllers share it. Each presents decoded header fields of every segment it accepts, marked as first and/or last. A doorbell or single-segment message is one segment carrying both marks. A multi-segment message is tracked by its source ID, mailbox and letter from its first segment to its last. Up to four such messages may be open at once in each controller.

A shared 32-bit ordering counter is sampled when a first segment is accepted. The descriptor is only built when the last segment arrives, so descriptors can leave in a different order from their ordering numbers. Word 1 carries a QoS and a group value taken from a 256-entry table, plus a per-controller tag. Both controllers index that table with a byte formed from header fields. The table has one read per cycle, granted round-robin; a controller that is waiting holds back its segment stream and never drops a message.

The segment input of each controller is valid/ready. A segment is taken on a clock edge where both are high. `seg_ready` falls for a first-and-last or a last segment while that controller still holds a descriptor that is not yet delivered. It also falls for a first segment when no context is free. The descriptor output is valid/ready too: once raised, `desc_valid` and both words stay unchanged until the edge where `desc_ready` is high.

Top module: `msg_desc_gen`

## Requirements
- R1: After reset no `desc_valid` is high, every `seg_ready` is high, and the first message accepted gets ordering number 0.
- R2: Word 0 holds, from bit 63 down: priority [63:62], 16-bit-ID flag [61], secondary-ID-hit flag [60], size code [59:56], source ID [55:40], extended mailbox [39:36], mailbox [35:34], letter [33:32], ordering number [31:0].
- R3: When the 16-bit-ID flag is 0, source ID bits [15:8] in word 0 are zero, whatever was presented.
- R4: The extended mailbox is copied into word 0 for a single-segment message, and is zero for a message whose first segment is not also its last.
- R5: One shared counter supplies the ordering number at each accepted first segment and then advances by one per message. When both controllers accept a first segment on the same edge, controller 0 gets the lower number.
- R6: A descriptor appears only after a last segment. Its header fields and ordering number come from the message's first segment, so output order may differ from ordering-number order.
- R7: The table index is {priority, 16-bit-ID flag, secondary-ID-hit flag, mailbox, letter}. Word 1 holds the entry's QoS in [42:40], its group in [35:32] and the controller's tag in [31:0]; all other bits are zero.
- R8: A table write takes effect from the next clock on. A lookup granted on the same edge as a write to its entry returns the old entry.
- R9: The table is granted to at most one controller per cycle. When both wait, the one not granted most recently wins; the other follows on the next cycle and nothing is lost.
- R10: A raised descriptor holds its words until accepted. While a controller's descriptor is still in flight, its `seg_ready` is low for a first-and-last segment.
- R11: Each controller tracks up to 4 open messages. A first segment with a new key while all 4 are open stalls (`seg_ready` low) and consumes no ordering number.
- R12: A last segment that is not a first segment and matches no open message is accepted and ignored: no descriptor, no ordering number.
- R13: With no table contention, `desc_valid` rises on the second clock edge after the edge that accepts the last segment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| seg_valid | input | NCTRL | Segment valid, one per controller |
| seg_ready | output | NCTRL | Segment accepted when high with valid |
| seg_first | input | NCTRL | Segment is the first of its message |
| seg_last | input | NCTRL | Segment is the last of its message |
| seg_prio | input | NCTRL x 2 | Priority |
| seg_wide | input | NCTRL | 1 = 16-bit IDs, 0 = 8-bit IDs |
| seg_sec | input | NCTRL | Destination matched the secondary local ID |
| seg_ssize | input | NCTRL x 4 | Segment size code |
| seg_src | input | NCTRL x 16 | Source ID |
| seg_xmbox | input | NCTRL x 4 | Extended mailbox |
| seg_mbox | input | NCTRL x 2 | Mailbox |
| seg_letter | input | NCTRL x 2 | Letter |
| tag_cfg | input | NCTRL x 32 | Per-controller tag for word 1 |
| tbl_we | input | 1 | Table write strobe |
| tbl_addr | input | 8 | Table write index |
| tbl_qos | input | 3 | QoS value to write |
| tbl_grp | input | 4 | Group value to write |
| desc_valid | output | NCTRL | Descriptor valid |
| desc_ready | input | NCTRL | Descriptor accepted when high with valid |
| desc_w0 | output | NCTRL x 64 | Descriptor word 0 |
| desc_w1 | output | NCTRL x 64 | Descriptor word 1 |

## Verification
A descriptor takes two register stages: the last segment loads a pending slot, and the table grant loads the output. The bench drives inputs on the falling edge. It checks that `desc_valid` is still low half a cycle after the accepting edge and high one full cycle later. A controller that loses arbitration is expected exactly one cycle after the winner. For the table write test, the write is driven during the cycle whose closing edge performs the grant, so the old entry must come out. Stall behaviour (`seg_ready` low) is read one time unit after the inputs are driven, before the next edge.

// File: rtl/msg_desc_pkg.sv
package msg_desc_pkg;
  localparam int SEQ_W  = 32;
  localparam int TBL_AW = 8;
  localparam int QOS_W  = 3;
  localparam int GRP_W  = 4;
  localparam int TAG_W  = 32;
  localparam int WORD_W = 64;

  typedef struct packed {
    logic [1:0]  prio;
    logic        wide;
    logic        sec;
    logic [3:0]  ssize;
    logic [15:0] src;
    logic [3:0]  xmbox;
    logic [1:0]  mbox;
    logic [1:0]  letter;
  } seg_hdr_t;

  typedef logic [TBL_AW-1:0] tbl_idx_t;

  // 8-bit IDs carry nothing in the upper source byte
  function automatic seg_hdr_t narrow_src(seg_hdr_t h);
    seg_hdr_t r;
    r = h;
    if (!h.wide) r.src[15:8] = '0;
    return r;
  endfunction

  function automatic tbl_idx_t tbl_index(seg_hdr_t h);
    return {h.prio, h.wide, h.sec, h.mbox, h.letter};
  endfunction

  function automatic logic [WORD_W-1:0] pack_w0(seg_hdr_t h, logic [SEQ_W-1:0] seq,
                                                logic multi);
    logic [3:0] xm;
    xm = multi ? 4'd0 : h.xmbox;
    return {h.prio, h.wide, h.sec, h.ssize, h.src, xm, h.mbox, h.letter, seq};
  endfunction

  function automatic logic [WORD_W-1:0] pack_w1(logic [QOS_W-1:0] qos,
                                                logic [GRP_W-1:0] grp,
                                                logic [TAG_W-1:0] tag);
    return {21'd0, qos, 4'd0, grp, tag};
  endfunction
endpackage

// File: rtl/msg_ctx_track.sv
// Per-controller tracking of open messages and word-0 assembly
module msg_ctx_track
  import msg_desc_pkg::*;
#(
  parameter int NCTX = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              seg_valid,
  input  logic              seg_first,
  input  logic              seg_last,
  input  seg_hdr_t          hdr,
  input  logic              busy,
  input  logic [SEQ_W-1:0]  seq_in,
  output logic              seg_ready,
  output logic              first_take,
  output logic              done_vld,
  output logic [WORD_W-1:0] done_w0,
  output tbl_idx_t          done_idx
);
  localparam int IW    = (NCTX > 1) ? $clog2(NCTX) : 1;
  localparam int KEY_W = 1 + 16 + 2 + 2;

  seg_hdr_t          hn;
  logic [KEY_W-1:0]  key;
  logic [NCTX-1:0]   ctx_v;
  seg_hdr_t          ctx_h   [NCTX];
  logic [SEQ_W-1:0]  ctx_seq [NCTX];
  logic [NCTX-1:0]   match;
  logic              hit, free_any;
  logic [IW-1:0]     hit_idx, free_idx, slot;
  logic              take, single;

  assign hn  = narrow_src(hdr);
  assign key = {hn.wide, hn.src, hn.mbox, hn.letter};

  for (genvar i = 0; i < NCTX; i++) begin : g_match
    assign match[i] = ctx_v[i] &&
                      (key == {ctx_h[i].wide, ctx_h[i].src, ctx_h[i].mbox, ctx_h[i].letter});
  end

  always_comb begin
    hit      = |match;
    free_any = ~&ctx_v;
    hit_idx  = '0;
    free_idx = '0;
    for (int i = NCTX - 1; i >= 0; i--) begin
      if (match[i]) hit_idx = IW'(i);
      if (!ctx_v[i]) free_idx = IW'(i);
    end
  end

  assign single = seg_first && seg_last;

  always_comb begin
    if (single)         seg_ready = !busy;
    else if (seg_first) seg_ready = hit || free_any;
    else if (seg_last)  seg_ready = !busy;
    else                seg_ready = 1'b1;
  end

  assign take       = seg_valid && seg_ready;
  assign first_take = take && seg_first;
  assign done_vld   = take && seg_last && (seg_first || hit);
  assign slot       = hit ? hit_idx : free_idx;

  always_comb begin
    if (seg_first) begin
      done_w0  = pack_w0(hn, seq_in, 1'b0);
      done_idx = tbl_index(hn);
    end else begin
      done_w0  = pack_w0(ctx_h[hit_idx], ctx_seq[hit_idx], 1'b1);
      done_idx = tbl_index(ctx_h[hit_idx]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctx_v <= '0;
    end else if (take && seg_first && !seg_last) begin
      ctx_v[slot] <= 1'b1;
    end else if (take && seg_last && !seg_first && hit) begin
      ctx_v[hit_idx] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (take && seg_first && !seg_last) begin
      ctx_h[slot]   <= hn;
      ctx_seq[slot] <= seq_in;
    end
  end
endmodule

// File: rtl/msg_rr_arb.sv
// Round-robin grant of one requester per cycle
module msg_rr_arb #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt
);
  localparam int PW = (N > 1) ? $clog2(N) : 1;

  logic [PW-1:0] ptr;
  logic [PW-1:0] win;

  always_comb begin
    int j;
    gnt = '0;
    win = '0;
    for (int k = 0; k < N; k++) begin
      j = (int'(ptr) + k) % N;
      if (gnt == '0 && req[j]) begin
        gnt[j] = 1'b1;
        win    = PW'(j);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr <= '0;
    else if (|gnt) ptr <= (int'(win) == N - 1) ? '0 : win + PW'(1);
  end
endmodule

// File: rtl/msg_qos_table.sv
// Programmable QoS/group table: write at the edge, asynchronous read
module msg_qos_table
  import msg_desc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  tbl_idx_t         waddr,
  input  logic [QOS_W-1:0] wqos,
  input  logic [GRP_W-1:0] wgrp,
  input  tbl_idx_t         raddr,
  output logic [QOS_W-1:0] rqos,
  output logic [GRP_W-1:0] rgrp
);
  localparam int DEPTH = 1 << TBL_AW;
  localparam int ENT_W = QOS_W + GRP_W;

  logic [ENT_W-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we) begin
      mem[waddr] <= {wqos, wgrp};
    end
  end

  assign {rqos, rgrp} = mem[raddr];
endmodule

// File: rtl/msg_desc_gen.sv
module msg_desc_gen
  import msg_desc_pkg::*;
#(
  parameter int NCTRL = 2,
  parameter int NCTX  = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NCTRL-1:0]       seg_valid,
  output logic [NCTRL-1:0]       seg_ready,
  input  logic [NCTRL-1:0]       seg_first,
  input  logic [NCTRL-1:0]       seg_last,
  input  logic [NCTRL-1:0][1:0]  seg_prio,
  input  logic [NCTRL-1:0]       seg_wide,
  input  logic [NCTRL-1:0]       seg_sec,
  input  logic [NCTRL-1:0][3:0]  seg_ssize,
  input  logic [NCTRL-1:0][15:0] seg_src,
  input  logic [NCTRL-1:0][3:0]  seg_xmbox,
  input  logic [NCTRL-1:0][1:0]  seg_mbox,
  input  logic [NCTRL-1:0][1:0]  seg_letter,
  input  logic [NCTRL-1:0][31:0] tag_cfg,
  input  logic                   tbl_we,
  input  logic [7:0]             tbl_addr,
  input  logic [2:0]             tbl_qos,
  input  logic [3:0]             tbl_grp,
  output logic [NCTRL-1:0]       desc_valid,
  input  logic [NCTRL-1:0]       desc_ready,
  output logic [NCTRL-1:0][63:0] desc_w0,
  output logic [NCTRL-1:0][63:0] desc_w1
);
  logic [SEQ_W-1:0]  seq_q;
  logic [SEQ_W-1:0]  seq_in   [NCTRL];
  logic [NCTRL-1:0]  first_take, done_vld, busy;
  logic [WORD_W-1:0] done_w0  [NCTRL];
  tbl_idx_t          done_idx [NCTRL];

  logic [NCTRL-1:0]  pend_v, out_v, gnt;
  logic [WORD_W-1:0] pend_w0  [NCTRL];
  tbl_idx_t          pend_idx [NCTRL];
  logic [WORD_W-1:0] out_w0   [NCTRL];
  logic [WORD_W-1:0] out_w1   [NCTRL];

  tbl_idx_t          lut_idx;
  logic [QOS_W-1:0]  lut_qos;
  logic [GRP_W-1:0]  lut_grp;

  assign busy = pend_v | out_v;

  for (genvar c = 0; c < NCTRL; c++) begin : g_ctrl
    localparam logic [NCTRL-1:0] LOWER = NCTRL'((1 << c) - 1);
    seg_hdr_t hdr;

    assign hdr = '{prio: seg_prio[c], wide: seg_wide[c], sec: seg_sec[c],
                   ssize: seg_ssize[c], src: seg_src[c], xmbox: seg_xmbox[c],
                   mbox: seg_mbox[c], letter: seg_letter[c]};

    // lower-numbered controllers take their numbers first on a shared edge
    assign seq_in[c] = seq_q + SEQ_W'($countones(first_take & LOWER));

    msg_ctx_track #(.NCTX(NCTX)) u_track (
      .clk        (clk),
      .rst_n      (rst_n),
      .seg_valid  (seg_valid[c]),
      .seg_first  (seg_first[c]),
      .seg_last   (seg_last[c]),
      .hdr        (hdr),
      .busy       (busy[c]),
      .seq_in     (seq_in[c]),
      .seg_ready  (seg_ready[c]),
      .first_take (first_take[c]),
      .done_vld   (done_vld[c]),
      .done_w0    (done_w0[c]),
      .done_idx   (done_idx[c])
    );

    assign desc_valid[c] = out_v[c];
    assign desc_w0[c]    = out_w0[c];
    assign desc_w1[c]    = out_w1[c];
  end

  msg_rr_arb #(.N(NCTRL)) u_arb (
    .clk   (clk),
    .rst_n (rst_n),
    .req   (pend_v),
    .gnt   (gnt)
  );

  always_comb begin
    lut_idx = '0;
    for (int c = 0; c < NCTRL; c++)
      if (gnt[c]) lut_idx = pend_idx[c];
  end

  msg_qos_table u_tbl (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (tbl_we),
    .waddr (tbl_addr),
    .wqos  (tbl_qos),
    .wgrp  (tbl_grp),
    .raddr (lut_idx),
    .rqos  (lut_qos),
    .rgrp  (lut_grp)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seq_q  <= '0;
      pend_v <= '0;
      out_v  <= '0;
    end else begin
      seq_q <= seq_q + SEQ_W'($countones(first_take));
      for (int c = 0; c < NCTRL; c++) begin
        if (done_vld[c])   pend_v[c] <= 1'b1;
        else if (gnt[c])   pend_v[c] <= 1'b0;
        if (gnt[c])             out_v[c] <= 1'b1;
        else if (desc_ready[c]) out_v[c] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int c = 0; c < NCTRL; c++) begin
      if (done_vld[c]) begin
        pend_w0[c]  <= done_w0[c];
        pend_idx[c] <= done_idx[c];
      end
      if (gnt[c]) begin
        out_w0[c] <= pend_w0[c];
        out_w1[c] <= pack_w1(lut_qos, lut_grp, tag_cfg[c]);
      end
    end
  end
endmodule

// File: rtl/msg_desc_gen_chk.sv
module msg_desc_gen_chk #(
  parameter int NCTRL = 2
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [NCTRL-1:0]       desc_valid,
  input logic [NCTRL-1:0]       desc_ready,
  input logic [NCTRL-1:0][63:0] desc_w0,
  input logic [NCTRL-1:0][63:0] desc_w1,
  input logic [NCTRL-1:0]       gnt,
  input logic [NCTRL-1:0]       req
);
  assert_grant_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt));

  assert_grant_needs_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt & ~req) == '0);

  for (genvar c = 0; c < NCTRL; c++) begin : g_chk
    assert_hold_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
      desc_valid[c] && !desc_ready[c] |=>
        desc_valid[c] && $stable(desc_w0[c]) && $stable(desc_w1[c]));

    assert_narrow_src_R3: assert property (@(posedge clk) disable iff (!rst_n)
      desc_valid[c] && !desc_w0[c][61] |-> desc_w0[c][55:48] == 8'h00);

    assert_w1_spare_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
      desc_valid[c] |-> desc_w1[c][63:43] == '0 && desc_w1[c][39:36] == '0);

    assert_rise_after_grant_R13: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(desc_valid[c]) |-> $past(gnt[c]));
  end
endmodule

bind msg_desc_gen msg_desc_gen_chk #(.NCTRL(NCTRL)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .desc_valid (desc_valid),
  .desc_ready (desc_ready),
  .desc_w0    (desc_w0),
  .desc_w1    (desc_w1),
  .gnt        (gnt),
  .req        (pend_v)
);

// File: tb/msg_desc_gen_bench.sv
module msg_desc_gen_bench;
  localparam int NC = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [NC-1:0]       seg_valid, seg_ready, seg_first, seg_last, seg_wide, seg_sec;
  logic [NC-1:0][1:0]  seg_prio, seg_mbox, seg_letter;
  logic [NC-1:0][3:0]  seg_ssize, seg_xmbox;
  logic [NC-1:0][15:0] seg_src;
  logic [NC-1:0][31:0] tag_cfg;
  logic                tbl_we;
  logic [7:0]          tbl_addr;
  logic [2:0]          tbl_qos;
  logic [3:0]          tbl_grp;
  logic [NC-1:0]       desc_valid, desc_ready;
  logic [NC-1:0][63:0] desc_w0, desc_w1;

  int checks = 0;
  int errors = 0;
  logic [31:0] exp_seq = 32'd0;
  logic [6:0]  tmodel [256];
  int last_g = 1;

  msg_desc_gen #(.NCTRL(NC), .NCTX(4)) u_msg_desc_gen (
    .clk(clk), .rst_n(rst_n), .seg_valid(seg_valid), .seg_ready(seg_ready),
    .seg_first(seg_first), .seg_last(seg_last), .seg_prio(seg_prio), .seg_wide(seg_wide),
    .seg_sec(seg_sec), .seg_ssize(seg_ssize), .seg_src(seg_src), .seg_xmbox(seg_xmbox),
    .seg_mbox(seg_mbox), .seg_letter(seg_letter), .tag_cfg(tag_cfg), .tbl_we(tbl_we),
    .tbl_addr(tbl_addr), .tbl_qos(tbl_qos), .tbl_grp(tbl_grp), .desc_valid(desc_valid),
    .desc_ready(desc_ready), .desc_w0(desc_w0), .desc_w1(desc_w1)
  );

  task automatic chk(string r, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  function automatic logic [31:0] mkh(logic [1:0] p, logic w, logic s, logic [3:0] sz,
                                      logic [15:0] src, logic [3:0] xm, logic [1:0] mb,
                                      logic [1:0] lt);
    return {p, w, s, sz, src, xm, mb, lt};
  endfunction

  function automatic logic [63:0] ew0(logic [31:0] h, logic [31:0] seq, logic multi);
    logic [15:0] src;
    logic [3:0]  xm;
    src = h[29] ? h[23:8] : {8'h00, h[15:8]};
    xm  = multi ? 4'h0 : h[7:4];
    return {h[31:24], src, xm, h[3:0], seq};
  endfunction

  function automatic logic [7:0] eidx(logic [31:0] h);
    return {h[31:28], h[3:0]};
  endfunction

  function automatic logic [63:0] ew1(int c, logic [31:0] h);
    logic [6:0] e;
    e = tmodel[eidx(h)];
    return {21'd0, e[6:4], 4'd0, e[3:0], tag_cfg[c]};
  endfunction

  task automatic drive(int c, logic [31:0] h, logic f, logic l);
    seg_prio[c] = h[31:30]; seg_wide[c] = h[29]; seg_sec[c] = h[28];
    seg_ssize[c] = h[27:24]; seg_src[c] = h[23:8]; seg_xmbox[c] = h[7:4];
    seg_mbox[c] = h[3:2]; seg_letter[c] = h[1:0];
    seg_first[c] = f; seg_last[c] = l;
  endtask

  // returns on the falling edge after the accepting edge
  task automatic send(int c, logic [31:0] h, logic f, logic l);
    @(negedge clk);
    drive(c, h, f, l);
    seg_valid[c] = 1'b1;
    #1;
    while (!seg_ready[c]) begin
      @(negedge clk);
      #1;
    end
    @(negedge clk);
    seg_valid[c] = 1'b0;
  endtask

  task automatic pop(int c, logic [63:0] w0e, logic [63:0] w1e, string r);
    chk({r, " valid"}, 64'(desc_valid[c]), 64'd1);
    chk({r, " word0"}, desc_w0[c], w0e);
    chk({r, " word1"}, desc_w1[c], w1e);
    desc_ready[c] = 1'b1;
    @(negedge clk);
    desc_ready[c] = 1'b0;
    chk({r, " valid drops after accept"}, 64'(desc_valid[c]), 64'd0);
  endtask

  task automatic twr(logic [7:0] a, logic [2:0] q, logic [3:0] g);
    @(negedge clk);
    tbl_we = 1'b1; tbl_addr = a; tbl_qos = q; tbl_grp = g;
    @(negedge clk);
    tbl_we = 1'b0;
    tmodel[a] = {q, g};
  endtask

  task automatic test_reset();
    chk("R1 no descriptor after reset", 64'(desc_valid), 64'd0);
    chk("R1 all inputs ready after reset", 64'(seg_ready), 64'(2'b11));
  endtask

  task automatic test_single();
    logic [31:0] h;
    logic [63:0] w0e, w1e;
    h = mkh(2'd2, 1'b0, 1'b1, 4'h9, 16'hAB12, 4'h5, 2'd1, 2'd3);
    twr(eidx(h), 3'd5, 4'hA);
    send(0, h, 1'b1, 1'b1);
    w0e = ew0(h, exp_seq, 1'b0);
    w1e = ew1(0, h);
    exp_seq++;
    chk("R13 not valid one edge after accept", 64'(desc_valid[0]), 64'd0);
    @(negedge clk);
    chk("R13 valid two edges after accept", 64'(desc_valid[0]), 64'd1);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R10 word0 held while not accepted", desc_w0[0], w0e);
      chk("R10 word1 held while not accepted", desc_w1[0], w1e);
    end
    @(negedge clk);
    drive(0, h, 1'b1, 1'b1);
    seg_valid[0] = 1'b1;
    #1;
    chk("R10 single stalls while descriptor pending", 64'(seg_ready[0]), 64'd0);
    seg_valid[0] = 1'b0;
    pop(0, w0e, w1e, "R2 R3 R4 R5 R7 single narrow-ID message");
    last_g = 0;
  endtask

  task automatic test_wide();
    logic [31:0] h;
    h = mkh(2'd1, 1'b1, 1'b0, 4'h2, 16'hAB12, 4'hE, 2'd2, 2'd1);
    twr(eidx(h), 3'd3, 4'h6);
    send(1, h, 1'b1, 1'b1);
    @(negedge clk);
    pop(1, ew0(h, exp_seq, 1'b0), ew1(1, h), "R3 R7 wide ID keeps upper byte, tag of ctrl1");
    exp_seq++;
    last_g = 1;
  endtask

  task automatic test_multi();
    logic [31:0] ha, hb, ha_last;
    logic [31:0] sa, sb;
    ha = mkh(2'd3, 1'b0, 1'b0, 4'h4, 16'h0033, 4'h7, 2'd0, 2'd1);
    hb = mkh(2'd0, 1'b1, 1'b1, 4'hB, 16'h1244, 4'h9, 2'd2, 2'd0);
    ha_last = mkh(2'd1, 1'b0, 1'b1, 4'h1, 16'h0033, 4'h0, 2'd0, 2'd1);
    send(0, ha, 1'b1, 1'b0); sa = exp_seq; exp_seq++;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R6 no descriptor after first segment", 64'(desc_valid[0]), 64'd0);
    end
    send(0, ha, 1'b0, 1'b0);
    send(0, hb, 1'b1, 1'b0); sb = exp_seq; exp_seq++;
    send(0, hb, 1'b0, 1'b1);
    @(negedge clk);
    pop(0, ew0(hb, sb, 1'b1), ew1(0, hb), "R4 R6 later message first, xmbox zeroed");
    send(0, ha_last, 1'b0, 1'b1);
    @(negedge clk);
    pop(0, ew0(ha, sa, 1'b1), ew1(0, ha), "R6 fields and number from first segment");
    last_g = 0;
  endtask

  task automatic test_ctx_full();
    logic [31:0] hk [5];
    logic [31:0] s0, hs;
    for (int k = 0; k < 5; k++)
      hk[k] = mkh(2'd1, 1'b0, 1'b0, 4'h3, 16'h0010 + 16'(k), 4'h0, 2'd3, 2'd2);
    s0 = exp_seq;
    for (int k = 0; k < 4; k++) begin
      send(0, hk[k], 1'b1, 1'b0);
      exp_seq++;
    end
    @(negedge clk);
    drive(0, hk[4], 1'b1, 1'b0);
    seg_valid[0] = 1'b1;
    #1;
    chk("R11 fifth open message stalls", 64'(seg_ready[0]), 64'd0);
    @(negedge clk);
    #1;
    chk("R11 fifth open message still stalled", 64'(seg_ready[0]), 64'd0);
    seg_valid[0] = 1'b0;
    for (int k = 0; k < 4; k++) begin
      send(0, hk[k], 1'b0, 1'b1);
      @(negedge clk);
      pop(0, ew0(hk[k], s0 + 32'(k), 1'b1), ew1(0, hk[k]), "R11 open message completes");
    end
    hs = mkh(2'd0, 1'b0, 1'b0, 4'h1, 16'h0099, 4'h2, 2'd0, 2'd0);
    send(0, hs, 1'b1, 1'b1);
    @(negedge clk);
    pop(0, ew0(hs, s0 + 32'd4, 1'b0), ew1(0, hs), "R11 stalled first consumed no number");
    exp_seq++;
    last_g = 0;
  endtask

  task automatic test_orphan();
    logic [31:0] ho, hs;
    ho = mkh(2'd2, 1'b0, 1'b0, 4'h1, 16'h0077, 4'h0, 2'd1, 2'd1);
    send(1, ho, 1'b0, 1'b1);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R12 unmatched last gives no descriptor", 64'(desc_valid[1]), 64'd0);
    end
    hs = mkh(2'd3, 1'b1, 1'b0, 4'hF, 16'h8001, 4'h3, 2'd1, 2'd0);
    send(1, hs, 1'b1, 1'b1);
    @(negedge clk);
    pop(1, ew0(hs, exp_seq, 1'b0), ew1(1, hs), "R12 unmatched last used no number");
    exp_seq++;
    last_g = 1;
  endtask

  task automatic test_rr();
    logic [31:0] h0, h1;
    logic [63:0] e0w0, e0w1, e1w0, e1w1;
    int win, lose;
    h0 = mkh(2'd1, 1'b1, 1'b0, 4'h6, 16'h4242, 4'h1, 2'd2, 2'd2);
    h1 = mkh(2'd1, 1'b1, 1'b0, 4'h6, 16'h4343, 4'h1, 2'd2, 2'd2);
    win  = (last_g == 0) ? 1 : 0;
    lose = 1 - win;
    @(negedge clk);
    drive(0, h0, 1'b1, 1'b1);
    drive(1, h1, 1'b1, 1'b1);
    seg_valid = 2'b11;
    #1;
    chk("R5 both controllers ready", 64'(seg_ready), 64'(2'b11));
    @(negedge clk);
    seg_valid = 2'b00;
    e0w0 = ew0(h0, exp_seq, 1'b0);
    e1w0 = ew0(h1, exp_seq + 32'd1, 1'b0);
    e0w1 = ew1(0, h0);
    e1w1 = ew1(1, h1);
    exp_seq += 32'd2;
    @(negedge clk);
    chk("R9 one grant, least recent wins", 64'(desc_valid), 64'(1 << win));
    @(negedge clk);
    chk("R9 other follows next cycle", 64'(desc_valid), 64'(2'b11));
    pop(0, e0w0, e0w1, "R5 ctrl0 lower number on shared edge");
    pop(1, e1w0, e1w1, "R5 ctrl1 next number on shared edge");
    last_g = lose;
  endtask

  task automatic test_tblwr();
    logic [31:0] h;
    logic [63:0] w1_old;
    h = mkh(2'd3, 1'b1, 1'b1, 4'h2, 16'h5555, 4'h1, 2'd2, 2'd2);
    twr(eidx(h), 3'd1, 4'h1);
    send(0, h, 1'b1, 1'b1);
    w1_old = ew1(0, h);
    tbl_we = 1'b1; tbl_addr = eidx(h); tbl_qos = 3'd6; tbl_grp = 4'hC;
    @(negedge clk);
    tbl_we = 1'b0;
    tmodel[eidx(h)] = {3'd6, 4'hC};
    pop(0, ew0(h, exp_seq, 1'b0), w1_old, "R8 write on grant edge keeps old entry");
    exp_seq++;
    send(0, h, 1'b1, 1'b1);
    @(negedge clk);
    pop(0, ew0(h, exp_seq, 1'b0), ew1(0, h), "R8 later lookup sees new entry");
    exp_seq++;
    last_g = 0;
  endtask

  initial begin
    for (int i = 0; i < 256; i++) tmodel[i] = 7'd0;
    seg_valid = '0; seg_first = '0; seg_last = '0; seg_wide = '0; seg_sec = '0;
    seg_prio = '0; seg_mbox = '0; seg_letter = '0; seg_ssize = '0; seg_xmbox = '0;
    seg_src = '0; desc_ready = '0;
    tag_cfg[0] = 32'hC0FF_EE01;
    tag_cfg[1] = 32'h0BAD_F00D;
    tbl_we = 1'b0; tbl_addr = '0; tbl_qos = '0; tbl_grp = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    test_single();
    test_wide();
    test_multi();
    test_ctx_full();
    test_orphan();
    test_rr();
    test_tblwr();
    repeat (2) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule